// File: doc/BRIEF.md
# Programmable Clock Output Stage

This block is one output channel of a clock generator. It takes a fast source clock from an upstream fractional divider and divides it by a power of two chosen by a 3-bit code. It then drives a single-ended output clock together with an output-enable that controls the pad. The configuration comes from register images held elsewhere on the chip. These are a divide code, a per-channel control byte holding power-down and inversion, an eight-bit disable mask shared by all channels, and a byte that packs four 2-bit disable-state fields.

The channel selects its own bit of the shared mask and its own field of the packed byte from the parameter `CH_IDX`. Starting and stopping the clock never cuts a pulse short. The decision to run or stop is taken only on a falling source edge while the divided clock is low. While the channel is stopped, the pin is held low, held high or released to high impedance, or the channel ignores the disable entirely. Writing all ones to the mask stops every channel together before software reconfigures the clock tree.

Top module: `clkout_stage`

## Requirements
- R1: Divide code k (0 to 7) gives an output period of 2^k source cycles. For k of 1 or more the output is high for exactly 2^(k-1) of those cycles.
- R2: Code 000 passes the source clock through: the output is high while the source clock is high and low while it is low.
- R3: When the divide code differs from the one in use, the counter restarts at the next rising source edge. The divided clock is then low for the first half period.
- R4: The channel obeys only bit `CH_IDX` of `dis_mask`. The other seven bits have no effect on its output.
- R5: The channel's disable-state field is `dstate_reg[2*(CH_IDX%4)+1 : 2*(CH_IDX%4)]`. Code 00 holds the pin low, 01 holds it high, and 10 drives `clk_oe` low. Code 11 keeps the clock running even when the channel is disabled.
- R6: A change between running and stopped takes effect only at a falling source edge at which the divided clock is low, so no shortened pulse reaches the pin.
- R7: `ctrl_reg` bit 4 set inverts the running output clock.
- R8: `ctrl_reg` bit 7 set turns the driver off at once: `clk_oe` and `clk_out` are both 0, whatever the other settings are.
- R9: While `rst` is high, the counter is cleared, the code in use is 000 and the channel is stopped. The pin shows the level of its disable-state field.
- R10: A mask of 0xFF stops the channel at the next allowed boundary, unless its field is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock from the upstream divider |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 3 | Power-of-two divide code |
| ctrl_reg | input | 8 | Channel control: bit 7 power-down, bit 4 invert, other bits stored elsewhere |
| dis_mask | input | 8 | Shared disable mask, bit n for channel n |
| dstate_reg | input | 8 | Four packed 2-bit disable-state fields |
| clk_out | output | 1 | Output clock level |
| clk_oe | output | 1 | Pad output enable (0 means high impedance) |

## Verification
The hardest case to reach is a disable or enable request that arrives while a long divided clock is high. The stop must be deferred for several cycles and then land exactly on the first low falling edge. A random change to the mask almost never lines up with the long high phase of divide-by-64 or divide-by-128. The stimulus therefore includes a directed step that waits until the output is seen high, then flips the channel's mask bit and follows every half cycle until the output settles. Random traffic at short divide codes, with rare code changes and field rewrites, covers the interplay with restarts and power-down.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;

    // Level the pin takes while the channel is stopped
    typedef enum logic [1:0] {
        DS_LOW  = 2'b00,
        DS_HIGH = 2'b01,
        DS_HIZ  = 2'b10,
        DS_KEEP = 2'b11
    } dis_state_e;

    // Channel control byte layout
    typedef struct packed {
        logic       pdn;
        logic [1:0] spare_hi;
        logic       inv;
        logic [3:0] spare_lo;
    } ctrl_t;

    localparam int FIELDS_PER_BYTE = 4;
    localparam int FIELD_W         = 2;

    // Low bit of this channel's disable-state field in the packed byte
    function automatic int field_lsb(input int ch);
        return FIELD_W * (ch % FIELDS_PER_BYTE);
    endfunction

    // Counter width able to hold the largest divide length minus one
    function automatic int cnt_width(input int code_w);
        return ((1 << code_w) - 1 > 0) ? (1 << code_w) - 1 : 1;
    endfunction

endpackage

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q,
    output logic              lvl_q
);
    import clkout_pkg::*;

    localparam int CNT_W = cnt_width(CODE_W);
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [CNT_W:0]   len_t;

    cnt_t cnt_q;
    cnt_t cnt_d;
    cnt_t last_cur;
    cnt_t half_new;
    len_t len_cur;
    len_t len_new;
    logic lvl_d;
    logic restart;

    always_comb begin
        len_cur  = len_t'(1) << code_q;
        len_new  = len_t'(1) << code_in;
        last_cur = cnt_t'(len_cur - len_t'(1));
        half_new = cnt_t'(len_new >> 1);
        restart  = (code_in != code_q);
        if (restart || cnt_q == last_cur) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + cnt_t'(1);
        end
        lvl_d = (code_in != '0) && (cnt_d >= half_new);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            code_q <= '0;
            lvl_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            code_q <= code_in;
            lvl_q  <= lvl_d;
        end
    end

endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/1ps
module clkout_gate (
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    input  logic lvl,
    input  logic want_run,
    output logic run_q
);
    // Decided on the falling source edge; the divided clock must be low.
    logic boundary;

    always_comb begin
        boundary = bypass || !lvl;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else if (boundary) begin
            run_q <= want_run;
        end
    end

endmodule

// File: rtl/clkout_drive.sv
`timescale 1ns/1ps
module clkout_drive (
    input  logic                   src_clk,
    input  logic                   bypass,
    input  logic                   lvl,
    input  logic                   run,
    input  logic                   inv,
    input  logic                   pdn,
    input  clkout_pkg::dis_state_e ds,
    output logic                   pin_lvl,
    output logic                   pin_oe
);
    import clkout_pkg::*;

    logic src_lvl;
    logic held;

    always_comb begin
        src_lvl = bypass ? src_clk : lvl;
        held    = (ds == DS_HIGH);
        if (pdn) begin
            pin_lvl = 1'b0;
            pin_oe  = 1'b0;
        end else if (run) begin
            pin_lvl = src_lvl ^ inv;
            pin_oe  = 1'b1;
        end else begin
            pin_lvl = held;
            pin_oe  = (ds != DS_HIZ);
        end
    end

endmodule

// File: rtl/clkout_stage.sv
`timescale 1ns/1ps
module clkout_stage #(
    parameter int CODE_W = 3,
    parameter int N_CH   = 8,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] div_code,
    input  logic [7:0]        ctrl_reg,
    input  logic [N_CH-1:0]   dis_mask,
    input  logic [7:0]        dstate_reg,
    output logic              clk_out,
    output logic              clk_oe
);
    import clkout_pkg::*;

    localparam int FL = field_lsb(CH_IDX);

    ctrl_t             ctrl;
    dis_state_e        ds_sel;
    logic              dis_bit;
    logic              want_run;
    logic              bypass;
    logic [CODE_W-1:0] code_q;
    logic              div_lvl;
    logic              run_q;
    logic              pdn_w;
    logic              unused_bits;

    always_comb begin
        ctrl        = ctrl_t'(ctrl_reg);
        ds_sel      = dis_state_e'(dstate_reg[FL +: FIELD_W]);
        dis_bit     = dis_mask[CH_IDX];
        want_run    = !(dis_bit && ds_sel != DS_KEEP);
        bypass      = (code_q == '0);
        pdn_w       = ctrl.pdn;
        unused_bits = ^{ctrl.spare_hi, ctrl.spare_lo, dis_mask, dstate_reg};
    end

    clkout_divider #(.CODE_W(CODE_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .code_in (div_code),
        .code_q  (code_q),
        .lvl_q   (div_lvl)
    );

    clkout_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .bypass   (bypass),
        .lvl      (div_lvl),
        .want_run (want_run),
        .run_q    (run_q)
    );

    clkout_drive u_drv (
        .src_clk (clk),
        .bypass  (bypass),
        .lvl     (div_lvl),
        .run     (run_q),
        .inv     (ctrl.inv),
        .pdn     (pdn_w),
        .ds      (ds_sel),
        .pin_lvl (clk_out),
        .pin_oe  (clk_oe)
    );

endmodule

// File: rtl/clkout_stage_chk.sv
`timescale 1ns/1ps
module clkout_stage_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] div_code,
    input logic [CODE_W-1:0] code_q,
    input logic              lvl_q,
    input logic              run_q,
    input logic              pdn,
    input logic [1:0]        ds,
    input logic              clk_out,
    input logic              clk_oe
);

    // R8
    pdn_off_chk: assert property (@(negedge clk) disable iff (rst)
        pdn |-> (!clk_oe && !clk_out));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (div_code != code_q) |=> (!lvl_q && code_q == $past(div_code)));

    // R6
    boundary_chk: assert property (@(posedge clk) disable iff (rst)
        ((run_q != $past(run_q)) && code_q != '0) |-> !lvl_q);

    // R5
    hiz_src_chk: assert property (@(negedge clk) disable iff (rst)
        !clk_oe |-> (pdn || ds == 2'b10));

    // R1
    lvl_code_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_q |-> (code_q != '0));

endmodule

bind clkout_stage clkout_stage_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_code (div_code),
    .code_q   (code_q),
    .lvl_q    (div_lvl),
    .run_q    (run_q),
    .pdn      (pdn_w),
    .ds       (ds_sel),
    .clk_out  (clk_out),
    .clk_oe   (clk_oe)
);

// File: tb/test_clkout_stage.sv
`timescale 1ns/1ps
module test_clkout_stage;

    localparam int CH = 5;
    localparam int FL = 2 * (CH % 4);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] div_code = 3'd0;
    logic [7:0] ctrl_reg = 8'h00;
    logic [7:0] dis_mask = 8'h00;
    logic [7:0] dstate_reg = 8'h00;
    logic       clk_out;
    logic       clk_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    int m_code = 0;
    int m_ph = 0;
    bit m_lvl = 0;
    bit m_run = 0;
    bit hi_out = 0;

    always #10 clk = ~clk;

    clkout_stage #(.CODE_W(3), .N_CH(8), .CH_IDX(CH)) i_clkout_stage (
        .clk        (clk),
        .rst        (rst),
        .div_code   (div_code),
        .ctrl_reg   (ctrl_reg),
        .dis_mask   (dis_mask),
        .dstate_reg (dstate_reg),
        .clk_out    (clk_out),
        .clk_oe     (clk_oe)
    );

    task automatic model_pos();
        int n;
        if (rst) begin
            m_code = 0; m_ph = 0; m_lvl = 0;
        end else begin
            if (int'(div_code) != m_code) begin
                m_code = int'(div_code);
                m_ph = 0;
            end else begin
                n = 1 << m_code;
                m_ph = (m_ph + 1) % n;
            end
            n = 1 << m_code;
            m_lvl = (n > 1) && (m_ph >= n / 2);
        end
    endtask

    task automatic model_neg();
        logic [1:0] ds;
        bit want;
        ds = dstate_reg[FL +: 2];
        want = !(dis_mask[CH] && ds != 2'b11);
        if (rst) m_run = 0;
        else if (m_code == 0 || !m_lvl) m_run = want;
    endtask

    task automatic check(input string req, input string what,
                         input logic act_o, input logic act_e,
                         input logic exp_o, input logic exp_e);
        tests++;
        if (act_o !== exp_o || act_e !== exp_e) begin
            fails++;
            $display("FAIL %s %s: actual out=%0b oe=%0b expected out=%0b oe=%0b",
                     req, what, act_o, act_e, exp_o, exp_e);
        end
    endtask

    task automatic sample(input string req, input bit hi_phase);
        logic [1:0] ds;
        bit lv, eo, ee;
        ds = dstate_reg[FL +: 2];
        lv = (m_code == 0) ? hi_phase : m_lvl;
        if (ctrl_reg[7]) begin
            eo = 0; ee = 0;
        end else if (m_run) begin
            eo = lv ^ ctrl_reg[4]; ee = 1;
        end else begin
            eo = (ds == 2'b01); ee = (ds != 2'b10);
        end
        check(req, hi_phase ? "high-phase" : "low-phase", clk_out, clk_oe, eo, ee);
        if (hi_phase) hi_out = clk_out;
    endtask

    task automatic tick(input string req);
        @(posedge clk); model_pos(); #5; sample(req, 1'b1);
        @(negedge clk); model_neg(); #5; sample(req, 1'b0);
    endtask

    task automatic ticks(input string req, input int n);
        for (int i = 0; i < n; i++) tick(req);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL R9 watchdog: actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int ones;
        // R9: reset state, channel stopped showing its field level
        ticks("R9", 3);
        check("R9", "reset pin", clk_out, clk_oe, 1'b0, 1'b1);
        dstate_reg = 8'h04;        // field of channel 5 = 01, hold high
        tick("R9");
        check("R9", "reset hold-high", clk_out, clk_oe, 1'b1, 1'b1);
        dstate_reg = 8'h00;
        rst = 1'b0;

        // R2: divide by one passes the source clock
        ticks("R2", 6);

        // R1 / R3: every code, period and duty measured from restart
        for (int k = 1; k < 8; k++) begin
            div_code = 3'(k);
            tick("R3");
            check("R3", "restart low", hi_out, clk_oe, 1'b0, 1'b1);
            ones = hi_out ? 1 : 0;
            for (int i = 1; i < (1 << k); i++) begin
                tick("R1");
                if (hi_out) ones++;
            end
            tests++;
            if (ones != (1 << (k - 1))) begin
                fails++;
                $display("FAIL R1 code %0d: actual high cycles=%0d expected=%0d",
                         k, ones, 1 << (k - 1));
            end
        end

        // R3: code change mid-period restarts the count
        div_code = 3'd3;
        ticks("R3", 6);
        div_code = 3'd2;
        ticks("R3", 6);

        // R7: inversion on divided and bypassed clocks
        ctrl_reg = 8'h10;
        ticks("R7", 10);
        div_code = 3'd0;
        ticks("R7", 4);
        ctrl_reg = 8'h00;
        div_code = 3'd1;
        ticks("R7", 3);

        // R10: all-ones mask, field hold-high, then other codes (R5)
        dstate_reg = 8'h04;
        dis_mask = 8'hFF;
        ticks("R10", 8);
        check("R10", "stopped high", clk_out, clk_oe, 1'b1, 1'b1);
        dstate_reg = 8'h08;        // 10: release pad
        ticks("R5", 3);
        check("R5", "high impedance", clk_out, clk_oe, 1'b0, 1'b0);
        dstate_reg = 8'h00;
        ticks("R5", 3);
        check("R5", "held low", clk_out, clk_oe, 1'b0, 1'b1);
        dstate_reg = 8'h0C;        // 11: keep running
        ticks("R5", 6);
        dstate_reg = 8'hF3;        // own field 00, neighbours set
        ticks("R5", 4);

        // R4: every other mask bit set, channel keeps running
        dis_mask = 8'hDF;
        ticks("R4", 8);
        dis_mask = 8'h20;
        ticks("R4", 4);
        dis_mask = 8'h00;
        ticks("R4", 4);

        // R6: disable requested while a long divided clock is high
        div_code = 3'd4;
        dstate_reg = 8'h00;
        ticks("R6", 2);
        while (!hi_out) tick("R6");
        dis_mask = 8'h20;
        tick("R6");
        check("R6", "no runt after request", hi_out, clk_oe, 1'b1, 1'b1);
        ticks("R6", 12);
        dis_mask = 8'h00;
        ticks("R6", 20);

        // R8: power-down overrides everything
        ctrl_reg = 8'h90;
        ticks("R8", 4);
        dis_mask = 8'hFF;
        dstate_reg = 8'h04;
        ticks("R8", 4);
        check("R8", "driver off", clk_out, clk_oe, 1'b0, 1'b0);
        ctrl_reg = 8'h00;
        dis_mask = 8'h00;
        ticks("R8", 10);

        // random traffic against the model
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) dis_mask = 8'($urandom());
            if ($urandom_range(15) == 0) dstate_reg = 8'($urandom());
            if ($urandom_range(59) == 0) div_code = 3'($urandom_range(4));
            if ($urandom_range(79) == 0) ctrl_reg = {($urandom_range(5) == 0), 2'b00,
                                                     1'($urandom()), 4'($urandom())};
            tick("R6");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule